// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Control

This block is the feedback-divider sequencer of a PLL whose VCO output first passes through an external dual-modulus prescaler. Each rising edge of `clk` is one output pulse of that prescaler. The block steers the prescaler through `mod_ctl_o`. A high level asks for the upper modulus P+1 and a low level asks for P. It also emits one `div_pulse_o` per complete division cycle for the phase detector. Over one cycle the prescaler divides by P+1 for A pulses and by P for the other B−A pulses. One cycle therefore spans P·B + A VCO periods.

The swallow count A (7 bits), the main count B (11 bits) and the range select come from configuration latches. They are sampled only at a cycle boundary, so a rewrite part way through a cycle never disturbs the cycle in flight. The sampled range select is passed on to the prescaler as `wide_sel_q_o`, where 0 selects 64/65 and 1 selects 128/129. A combinational check on the live configuration drives `cfg_err_o` for settings the application forbids.

The sequencer has three named states. `ST_LOAD` is entered from reset and lasts one clock, in which the configuration is sampled. `ST_SWALLOW` holds the upper modulus. `ST_MAIN` holds the lower modulus. The transitions are:
- **load**: leaves `ST_LOAD`, or ends a cycle from either counting state. It enters `ST_SWALLOW` when A ≠ 0 and `ST_MAIN` when A = 0.
- **swallow-done**: goes from `ST_SWALLOW` to `ST_MAIN` once the A count is spent before the B count.
- **hold**: keeps the current state on every other clock.

Top module: `psdiv_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_ctl_o`, `div_pulse_o` and `wide_sel_q_o` are all 0.
- R2: Once running, successive `div_pulse_o` pulses are exactly B clocks apart, where B is the main count sampled at the boundary that starts the cycle.
- R3: In each cycle `mod_ctl_o` is high for exactly the first A clocks in one contiguous run. The run starts in the clock that carries `div_pulse_o`.
- R4: When the sampled A is 0, `mod_ctl_o` stays low for the whole cycle.
- R5: The VCO periods in one cycle, (P+1)·(high clocks) + P·(low clocks), equal P·B + A. P is 64 when the sampled select is 0 and 128 when it is 1.
- R6: `wide_sel_q_o` equals the range select sampled at the boundary that starts the current cycle.
- R7: A change to A, B or the select in the middle of a cycle has no effect on that cycle. The new values take effect from the next cycle.
- R8: With select = 0, `cfg_err_o` is 1 exactly when B < 384, B > 399, A > 64 or A > B.
- R9: With select = 1, `cfg_err_o` is 1 exactly when B < 192, B > 199 or A > B.
- R10: `div_pulse_o` is high for one clock per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output pulse, used as the clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swallow_i | input | 7 | Swallow count A from the configuration latch |
| main_i | input | 11 | Main count B from the configuration latch |
| wide_sel_i | input | 1 | Prescaler range select: 0 = 64/65, 1 = 128/129 |
| mod_ctl_o | output | 1 | Prescaler modulus control: 1 = P+1, 0 = P |
| div_pulse_o | output | 1 | One-clock pulse per completed division cycle |
| wide_sel_q_o | output | 1 | Range select applied to the current cycle |
| cfg_err_o | output | 1 | Live configuration is illegal |

## Verification
The assertions assume that every configuration sampled at a boundary is legal: B inside its window and A no larger than either its limit or B. Under that assumption a cycle always lasts several clocks and the swallow run always ends no later than the main count. Illegal settings are applied only while reset holds the sequencer in `ST_LOAD`, where the error flag is checked but nothing is sampled. All stimulus applied after reset, random or directed, is drawn inside the legal windows.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psdiv_state_e;

endpackage

// File: rtl/psdiv_cfg_chk.sv
module psdiv_cfg_chk #(
    parameter int A_W        = 7,
    parameter int B_W        = 11,
    parameter int B_MIN_NAR  = 384,
    parameter int B_MAX_NAR  = 399,
    parameter int A_MAX_NAR  = 64,
    parameter int B_MIN_WID  = 192,
    parameter int B_MAX_WID  = 199,
    parameter int A_MAX_WID  = 127
) (
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           wide_i,
    output logic           bad_o
);
    localparam logic [B_W-1:0] BLO_N = B_W'(B_MIN_NAR);
    localparam logic [B_W-1:0] BHI_N = B_W'(B_MAX_NAR);
    localparam logic [B_W-1:0] BLO_W = B_W'(B_MIN_WID);
    localparam logic [B_W-1:0] BHI_W = B_W'(B_MAX_WID);
    localparam logic [B_W-1:0] AMX_N = B_W'(A_MAX_NAR);
    localparam logic [B_W-1:0] AMX_W = B_W'(A_MAX_WID);

    logic [B_W-1:0] a_ext;
    logic           b_out;
    logic           a_out;

    always_comb begin
        a_ext = {{(B_W-A_W){1'b0}}, a_i};
        if (wide_i) begin
            b_out = (b_i < BLO_W) || (b_i > BHI_W);
            a_out = (a_ext > AMX_W);
        end else begin
            b_out = (b_i < BLO_N) || (b_i > BHI_N);
            a_out = (a_ext > AMX_N);
        end
        bad_o = b_out || a_out || (a_ext > b_i);
    end

endmodule

// File: rtl/psdiv_fsm.sv
module psdiv_fsm
    import psdiv_pkg::*;
#(
    parameter int A_W = 7,
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           wide_i,
    output logic           mod_hi_o,
    output logic           pulse_o,
    output logic           wide_q_o
);
    localparam logic [A_W-1:0] A_ONE = A_W'(1);
    localparam logic [B_W-1:0] B_ONE = B_W'(1);

    psdiv_state_e   state_q, state_d;
    logic [A_W-1:0] a_rem;
    logic [B_W-1:0] b_rem;
    logic           load;
    logic           last;

    // next-state process
    always_comb begin
        last    = (b_rem <= B_ONE);
        load    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    load = 1'b1;
            ST_SWALLOW: begin
                if (last)                load    = 1'b1;
                else if (a_rem <= A_ONE) state_d = ST_MAIN;
            end
            ST_MAIN:    if (last) load = 1'b1;
            default:    load = 1'b1;
        endcase
        if (load) state_d = (a_i != '0) ? ST_SWALLOW : ST_MAIN;
    end

    // state register with counters and the sampled select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_LOAD;
            a_rem    <= '0;
            b_rem    <= '0;
            wide_q_o <= 1'b0;
            pulse_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_o <= load && (state_q != ST_LOAD);
            if (load) begin
                a_rem    <= a_i;
                b_rem    <= b_i;
                wide_q_o <= wide_i;
            end else begin
                b_rem <= b_rem - B_ONE;
                if (state_q == ST_SWALLOW) a_rem <= a_rem - A_ONE;
            end
        end
    end

    // output process
    always_comb begin
        mod_hi_o = (state_q == ST_SWALLOW);
    end

    // R10: the cycle pulse never lasts two clocks
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R3: the upper modulus only starts at a cycle boundary
    a_r3_mod_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mod_hi_o) && ($past(state_q) != ST_LOAD)) |-> pulse_o);

    // R3: the swallow run never outlasts the main count
    a_r3_swallow_within_main: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWALLOW) |-> ((a_rem != '0) && ({{(B_W-A_W){1'b0}}, a_rem} <= b_rem)));

    // R7: the applied select moves only at a cycle boundary
    a_r7_sel_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wide_q_o) |-> (pulse_o || ($past(state_q) == ST_LOAD)));

endmodule

// File: rtl/psdiv_ctrl.sv
module psdiv_ctrl #(
    parameter int A_W        = 7,
    parameter int B_W        = 11,
    parameter int B_MIN_NAR  = 384,
    parameter int B_MAX_NAR  = 399,
    parameter int A_MAX_NAR  = 64,
    parameter int B_MIN_WID  = 192,
    parameter int B_MAX_WID  = 199,
    parameter int A_MAX_WID  = 127
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] swallow_i,
    input  logic [B_W-1:0] main_i,
    input  logic           wide_sel_i,
    output logic           mod_ctl_o,
    output logic           div_pulse_o,
    output logic           wide_sel_q_o,
    output logic           cfg_err_o
);

    psdiv_fsm #(.A_W(A_W), .B_W(B_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_i      (swallow_i),
        .b_i      (main_i),
        .wide_i   (wide_sel_i),
        .mod_hi_o (mod_ctl_o),
        .pulse_o  (div_pulse_o),
        .wide_q_o (wide_sel_q_o)
    );

    psdiv_cfg_chk #(
        .A_W(A_W), .B_W(B_W),
        .B_MIN_NAR(B_MIN_NAR), .B_MAX_NAR(B_MAX_NAR), .A_MAX_NAR(A_MAX_NAR),
        .B_MIN_WID(B_MIN_WID), .B_MAX_WID(B_MAX_WID), .A_MAX_WID(A_MAX_WID)
    ) u_chk (
        .a_i    (swallow_i),
        .b_i    (main_i),
        .wide_i (wide_sel_i),
        .bad_o  (cfg_err_o)
    );

    // R1: nothing toggles toward the prescaler while reset is held
    always_comb begin
        if (!rst_n) a_r1_quiet_in_reset: assert (!div_pulse_o && !mod_ctl_o);
    end

endmodule

// File: tb/psdiv_ctrl_tb.sv
module psdiv_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  swallow_i = '0;
    logic [10:0] main_i = 11'd390;
    logic        wide_sel_i = 1'b0;
    logic        mod_ctl_o, div_pulse_o, wide_sel_q_o, cfg_err_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psdiv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .swallow_i(swallow_i), .main_i(main_i),
        .wide_sel_i(wide_sel_i), .mod_ctl_o(mod_ctl_o), .div_pulse_o(div_pulse_o),
        .wide_sel_q_o(wide_sel_q_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input int a, input int b, input bit wide);
        bit e;
        if (wide) e = (b < 192) || (b > 199);
        else      e = (b < 384) || (b > 399) || (a > 64);
        return e || (a > b);
    endfunction

    task automatic set_cfg(input int a, input int b, input bit wide);
        swallow_i  = 7'(a);
        main_i     = 11'(b);
        wide_sel_i = wide;
    endtask

    task automatic cfg_probe(input int a, input int b, input bit wide);
        set_cfg(a, b, wide);
        #1;
        check(cfg_err_o == exp_err(a, b, wide), wide ? "R9 cfg_err" : "R8 cfg_err",
              int'(cfg_err_o), int'(exp_err(a, b, wide)));
    endtask

    task automatic sync_pulse();
        int g = 0;
        while (!div_pulse_o && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    // Called at a negedge that shows div_pulse_o; returns at the next one.
    task automatic measure(input int ea, input int eb, input bit ewide, input int chg_at,
                           input int na, input int nb, input bit nwide);
        int len = 0, hi = 0, pulses = 0, p;
        bit seen_low = 0, contig = 1;
        check(wide_sel_q_o == ewide, "R6 applied select", int'(wide_sel_q_o), int'(ewide));
        do begin
            if (chg_at >= 0 && len == chg_at) set_cfg(na, nb, nwide);
            if (div_pulse_o) pulses++;
            if (mod_ctl_o) begin
                hi++;
                if (seen_low) contig = 0;
            end else seen_low = 1;
            len++;
            @(negedge clk);
        end while (!div_pulse_o && len < 5000);
        p = ewide ? 128 : 64;
        check(len == eb, "R2 cycle length", len, eb);
        check(hi == ea, ea == 0 ? "R4 mod low for A=0" : "R3 high clocks", hi, ea);
        check(contig, "R3 contiguous leading run", int'(contig), 1);
        check((p + 1) * hi + p * (len - hi) == p * eb + ea, "R5 total division",
              (p + 1) * hi + p * (len - hi), p * eb + ea);
        check(pulses == 1, "R10 pulse width", pulses, 1);
    endtask

    task automatic run_cfg(input int a, input int b, input bit wide);
        set_cfg(a, b, wide);
        sync_pulse();
        @(negedge clk);
        sync_pulse();
        measure(a, b, wide, -1, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        check(!mod_ctl_o && !div_pulse_o && !wide_sel_q_o, "R1 reset state",
              int'({mod_ctl_o, div_pulse_o, wide_sel_q_o}), 0);
        // R8 / R9: configuration check, directed edges
        cfg_probe(64, 384, 0);  cfg_probe(65, 390, 0);  cfg_probe(0, 383, 0);
        cfg_probe(10, 400, 0);  cfg_probe(0, 399, 0);
        cfg_probe(127, 192, 1); cfg_probe(0, 199, 1);  cfg_probe(5, 191, 1);
        cfg_probe(5, 200, 1);   cfg_probe(100, 50, 1); cfg_probe(3, 2, 0);
        for (int i = 0; i < 20; i++) begin
            int a = $urandom_range(0, 127);
            int b = $urandom_range(150, 450);
            cfg_probe(a, b, 1'($urandom_range(0, 1)));
        end
        check(!mod_ctl_o && !div_pulse_o, "R1 reset state held", int'(mod_ctl_o), 0);

        set_cfg(10, 390, 0);
        @(negedge clk);
        rst_n = 1'b1;

        run_cfg(10, 390, 0);
        run_cfg(0, 384, 0);     // R4
        run_cfg(64, 384, 0);
        run_cfg(64, 399, 0);
        run_cfg(127, 192, 1);
        run_cfg(0, 199, 1);     // R4
        run_cfg(1, 195, 1);

        // R7: rewrite mid-cycle, the old values finish the cycle
        set_cfg(20, 396, 0);
        sync_pulse(); @(negedge clk); sync_pulse();
        measure(20, 396, 0, 37, 100, 197, 1);
        measure(100, 197, 1, 5, 3, 385, 0);
        measure(3, 385, 0, -1, 0, 0, 0);

        for (int i = 0; i < 12; i++) begin
            bit w = 1'($urandom_range(0, 1));
            int b = w ? $urandom_range(192, 199) : $urandom_range(384, 399);
            int a = w ? $urandom_range(0, 127) : $urandom_range(0, 64);
            run_cfg(a, b, w);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule